// File: doc/BRIEF.md
# Partial-Tag Branch Target Buffer

This block sits beside the instruction cache in a fetch stage and guesses where fetch should go next. Each cycle the current fetch-group address is presented on the lookup port. The set index and a shortened tag are taken from that address, and every way of the selected set compares its stored tag in parallel. When one way matches, the block rebuilds a full next fetch address. It does this by placing the stored low-order target bits under the upper bits of the lookup address. When no way matches, the next address is the sequential one: the lookup address plus the fetch-group size in bytes.

Entries are written only for transfers that resolved as taken. The update port either refreshes the way that already holds the branch or installs the branch into the set's replacement victim. A flush input discards every entry. Storage is kept small in two ways. The tag holds only a slice of the address, so unrelated branches may alias. The target holds only its low bits, so a target outside the lookup address's upper region is predicted wrongly. Later pipeline stages are expected to catch both kinds of error.

Top module: `ptag_btb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until an update is made.
- R2: On a miss, `lk_next_pc` equals `lk_pc + GROUP_BYTES` (16 by default), modulo 2^PC_W.
- R3: The set index is `lk_pc[5:4]` and the tag is `lk_pc[21:6]` with default parameters. A lookup hits only when a valid way of that set holds an equal tag.
- R4: On a hit, `lk_next_pc` is `{lk_pc[31:24], stored[23:0]}`: the stored 24 target bits sit under the upper 8 bits of the lookup address.
- R5: Address bits outside the index and tag fields (bits 31:22 and 3:0) take no part in the match, so addresses that differ only there alias to the same entry.
- R6: An update whose index and tag match a valid way rewrites that way's target and leaves the other way of the set untouched.
- R7: An update with no match writes the set's least recently written way and marks it valid. With two ways, a third distinct branch in a set evicts the one written longest ago.
- R8: A flush clears every valid bit on the next edge and takes priority over an update in the same cycle, which is then dropped.
- R9: An update becomes visible to lookups from the cycle after it is presented. A lookup in the same cycle sees the old contents.
- R10: Sets are independent. An update to one set never changes the result of lookups that index another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Invalidate all entries on the next edge |
| lk_pc | input | PC_W | Fetch-group address to look up |
| lk_hit | output | 1 | A valid way of the indexed set matched |
| lk_next_pc | output | PC_W | Predicted next fetch address |
| up_en | input | 1 | Install or refresh an entry this cycle |
| up_pc | input | PC_W | Fetch-group address of the resolved taken branch |
| up_tgt_lo | input | TGT_W | Low TGT_W bits of the resolved target |

## Verification
The bench builds the block with its defaults: 4 sets of 2 ways, a 16-bit tag, a 24-bit stored target, a 32-bit address and a 16-byte fetch group. With only two ways per set, three branches in one set are enough to reach eviction and the refresh-versus-replace ordering. The narrow 24-bit target field leaves 8 upper address bits free, and the random phase varies those bits together with bits 22 and up. This exercises both tag aliasing and the splicing of upper bits onto stored targets. Random addresses are confined to 16 tags per set, so refreshes, evictions and flushes occur often and are compared each cycle against a behavioural model.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
   // Replacement variant chosen from the way count.
   typedef enum logic {
      RP_LRU2 = 1'b0,
      RP_FIFO = 1'b1
   } ptb_repl_e;

   function automatic ptb_repl_e pick_repl(input int unsigned ways);
      return (ways == 2) ? RP_LRU2 : RP_FIFO;
   endfunction
endpackage

// File: rtl/ptb_way_store.sv
module ptb_way_store #(
   parameter int unsigned SETS  = 4,
   parameter int unsigned IDX_W = 2,
   parameter int unsigned TAG_W = 16,
   parameter int unsigned TGT_W = 24
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            flush,
   input  logic                            wr_en,
   input  logic [IDX_W-1:0]                wr_idx,
   input  logic [TAG_W-1:0]                wr_tag,
   input  logic [TGT_W-1:0]                wr_tgt,
   output logic [SETS-1:0]                 vld_o,
   output logic [SETS-1:0][TAG_W-1:0]      tag_o,
   output logic [SETS-1:0][TGT_W-1:0]      tgt_o
);
   logic [SETS-1:0]            vld_q;
   logic [SETS-1:0][TAG_W-1:0] tag_q;
   logic [SETS-1:0][TGT_W-1:0] tgt_q;

   // Valid bits carry reset and flush; flush wins over a write.
   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
      end
   end

   // Payload needs no reset: it is only read through a valid bit.
   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         tag_q[wr_idx] <= wr_tag;
         tgt_q[wr_idx] <= wr_tgt;
      end
   end

   assign vld_o = vld_q;
   assign tag_o = tag_q;
   assign tgt_o = tgt_q;
endmodule

// File: rtl/ptb_match.sv
module ptb_match #(
   parameter int unsigned WAYS  = 2,
   parameter int unsigned TAG_W = 16,
   parameter int unsigned TGT_W = 24
) (
   input  logic [WAYS-1:0]             vld,
   input  logic [WAYS-1:0][TAG_W-1:0]  tags,
   input  logic [WAYS-1:0][TGT_W-1:0]  tgts,
   input  logic [TAG_W-1:0]            key,
   output logic [WAYS-1:0]             hit_vec,
   output logic                        hit,
   output logic [TGT_W-1:0]            tgt
);
   // One comparator per way, all in parallel.
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = vld[w] && (tags[w] == key);
   end

   // AND-OR select; at most one way matches.
   always_comb begin
      tgt = '0;
      for (int w = 0; w < WAYS; w++) begin
         tgt = tgt | (hit_vec[w] ? tgts[w] : '0);
      end
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/ptb_victim.sv
module ptb_victim
   import ptb_pkg::*;
#(
   parameter int unsigned SETS  = 4,
   parameter int unsigned IDX_W = 2,
   parameter int unsigned WAYS  = 2,
   parameter int unsigned WAY_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WAY_W-1:0] wr_way,
   input  logic             wr_new,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [WAY_W-1:0] victim_o
);
   localparam ptb_repl_e REPL = pick_repl(WAYS);

   if (REPL == RP_LRU2) begin : g_lru
      // One bit per set naming the way written longest ago.
      logic [SETS-1:0] lru_q;
      wire unused_new = wr_new;

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            lru_q <= '0;
         end else if (wr_en) begin
            lru_q[wr_idx] <= ~wr_way[0];
         end
      end

      assign victim_o = WAY_W'(lru_q[rd_idx]);
   end else begin : g_fifo
      // Round-robin pointer advanced on installs only.
      logic [SETS-1:0][WAY_W-1:0] ptr_q;
      wire [WAY_W-1:0] unused_way = wr_way;

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            ptr_q <= '0;
         end else if (wr_en && wr_new) begin
            if (ptr_q[wr_idx] == WAY_W'(WAYS - 1)) begin
               ptr_q[wr_idx] <= '0;
            end else begin
               ptr_q[wr_idx] <= ptr_q[wr_idx] + 1'b1;
            end
         end
      end

      assign victim_o = ptr_q[rd_idx];
   end
endmodule

// File: rtl/ptag_btb.sv
module ptag_btb
   import ptb_pkg::*;
#(
   parameter int unsigned PC_W        = 32,
   parameter int unsigned SETS        = 4,
   parameter int unsigned WAYS        = 2,
   parameter int unsigned TAG_W       = 16,
   parameter int unsigned TGT_W       = 24,
   parameter int unsigned GROUP_BYTES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [PC_W-1:0]  lk_pc,
   output logic             lk_hit,
   output logic [PC_W-1:0]  lk_next_pc,
   input  logic             up_en,
   input  logic [PC_W-1:0]  up_pc,
   input  logic [TGT_W-1:0] up_tgt_lo
);
   localparam int unsigned OFS_W   = $clog2(GROUP_BYTES);
   localparam int unsigned IDX_W   = $clog2(SETS);
   localparam int unsigned TAG_LSB = OFS_W + IDX_W;
   localparam int unsigned TAG_MSB = TAG_LSB + TAG_W - 1;
   localparam int unsigned WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;

   // Elaboration-time parameter checks.
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (GROUP_BYTES < 2 || (1 << OFS_W) != GROUP_BYTES) begin : g_bad_grp
      $error("GROUP_BYTES must be a power of two, at least 2");
   end
   if (WAYS < 2) begin : g_bad_ways
      $error("WAYS must be at least 2");
   end
   if (TAG_MSB >= PC_W) begin : g_bad_tag
      $error("tag field runs past the address");
   end
   if (TGT_W >= PC_W || TGT_W <= TAG_LSB) begin : g_bad_tgt
      $error("TGT_W must be below PC_W and above the index field");
   end

   // Field extraction.
   logic [IDX_W-1:0] lk_idx, up_idx;
   logic [TAG_W-1:0] lk_tag, up_tag;

   assign lk_idx = lk_pc[TAG_LSB-1:OFS_W];
   assign lk_tag = lk_pc[TAG_MSB:TAG_LSB];
   assign up_idx = up_pc[TAG_LSB-1:OFS_W];
   assign up_tag = up_pc[TAG_MSB:TAG_LSB];

   wire unused_up_bits = ^{up_pc[PC_W-1:TAG_MSB+1], up_pc[OFS_W-1:0]};

   // Storage, one bank per way.
   logic [WAYS-1:0][SETS-1:0]            vld_all;
   logic [WAYS-1:0][SETS-1:0][TAG_W-1:0] tag_all;
   logic [WAYS-1:0][SETS-1:0][TGT_W-1:0] tgt_all;
   logic [WAYS-1:0]                      way_we;

   logic [WAYS-1:0]             lk_v, up_v;
   logic [WAYS-1:0][TAG_W-1:0]  lk_tags, up_tags;
   logic [WAYS-1:0][TGT_W-1:0]  lk_tgts, up_tgts;

   logic             up_wr;
   logic [WAY_W-1:0] up_way, up_hit_way, victim;

   assign up_wr = up_en && !flush;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign way_we[w] = up_wr && (up_way == WAY_W'(w));

      ptb_way_store #(
         .SETS  (SETS),
         .IDX_W (IDX_W),
         .TAG_W (TAG_W),
         .TGT_W (TGT_W)
      ) u_store (
         .clk    (clk),
         .rst_n  (rst_n),
         .flush  (flush),
         .wr_en  (way_we[w]),
         .wr_idx (up_idx),
         .wr_tag (up_tag),
         .wr_tgt (up_tgt_lo),
         .vld_o  (vld_all[w]),
         .tag_o  (tag_all[w]),
         .tgt_o  (tgt_all[w])
      );

      assign lk_v[w]    = vld_all[w][lk_idx];
      assign lk_tags[w] = tag_all[w][lk_idx];
      assign lk_tgts[w] = tgt_all[w][lk_idx];
      assign up_v[w]    = vld_all[w][up_idx];
      assign up_tags[w] = tag_all[w][up_idx];
      assign up_tgts[w] = tgt_all[w][up_idx];
   end

   // Lookup side.
   logic [WAYS-1:0]  lk_hitvec;
   logic [TGT_W-1:0] lk_tgt;

   ptb_match #(
      .WAYS  (WAYS),
      .TAG_W (TAG_W),
      .TGT_W (TGT_W)
   ) u_lk_match (
      .vld     (lk_v),
      .tags    (lk_tags),
      .tgts    (lk_tgts),
      .key     (lk_tag),
      .hit_vec (lk_hitvec),
      .hit     (lk_hit),
      .tgt     (lk_tgt)
   );

   assign lk_next_pc = lk_hit ? {lk_pc[PC_W-1:TGT_W], lk_tgt}
                              : lk_pc + PC_W'(GROUP_BYTES);

   // Update side: refresh a matching way, else take the victim.
   logic [WAYS-1:0]  up_hitvec;
   logic             up_hit;
   logic [TGT_W-1:0] unused_up_tgt;

   ptb_match #(
      .WAYS  (WAYS),
      .TAG_W (TAG_W),
      .TGT_W (TGT_W)
   ) u_up_match (
      .vld     (up_v),
      .tags    (up_tags),
      .tgts    (up_tgts),
      .key     (up_tag),
      .hit_vec (up_hitvec),
      .hit     (up_hit),
      .tgt     (unused_up_tgt)
   );

   always_comb begin
      up_hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (up_hitvec[w]) begin
            up_hit_way = WAY_W'(w);
         end
      end
   end

   assign up_way = up_hit ? up_hit_way : victim;

   ptb_victim #(
      .SETS  (SETS),
      .IDX_W (IDX_W),
      .WAYS  (WAYS),
      .WAY_W (WAY_W)
   ) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .wr_en    (up_wr),
      .wr_idx   (up_idx),
      .wr_way   (up_way),
      .wr_new   (!up_hit),
      .rd_idx   (up_idx),
      .victim_o (victim)
   );

   // Flat valid view for the bound checker.
   logic [WAYS*SETS-1:0] vld_flat;
   assign vld_flat = vld_all;
endmodule

// File: rtl/ptag_btb_chk.sv
module ptag_btb_chk #(
   parameter int unsigned PC_W        = 32,
   parameter int unsigned SETS        = 4,
   parameter int unsigned WAYS        = 2,
   parameter int unsigned IDX_W       = 2,
   parameter int unsigned GROUP_BYTES = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 flush,
   input logic                 up_en,
   input logic [IDX_W-1:0]     up_idx,
   input logic [WAYS*SETS-1:0] vld,
   input logic [WAYS-1:0]      hit_vec,
   input logic                 lk_hit,
   input logic [PC_W-1:0]      lk_pc,
   input logic [PC_W-1:0]      lk_next_pc
);
   logic [IDX_W-1:0] idx_q;
   logic             set_any;

   always_ff @(posedge clk) begin
      idx_q <= up_idx;
   end

   always_comb begin
      set_any = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         set_any = set_any | vld[w*SETS + int'(idx_q)];
      end
   end

   // R2
   miss_fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_next_pc == lk_pc + PC_W'(GROUP_BYTES)));

   // R3
   single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R7
   install_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_en && !flush) |=> set_any);

   // R8
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld == '0));

   // R9
   idle_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!up_en && !flush) |=> $stable(vld));
endmodule

bind ptag_btb ptag_btb_chk #(
   .PC_W        (PC_W),
   .SETS        (SETS),
   .WAYS        (WAYS),
   .IDX_W       (IDX_W),
   .GROUP_BYTES (GROUP_BYTES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .up_en      (up_en),
   .up_idx     (up_idx),
   .vld        (vld_flat),
   .hit_vec    (lk_hitvec),
   .lk_hit     (lk_hit),
   .lk_pc      (lk_pc),
   .lk_next_pc (lk_next_pc)
);

// File: tb/sim_ptag_btb.sv
`timescale 1ns/1ps
module sim_ptag_btb;
   localparam int NSETS = 4;
   localparam int NWAYS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_hit;
   logic [31:0] lk_next_pc;
   logic        up_en = 1'b0;
   logic [31:0] up_pc = '0;
   logic [23:0] up_tgt_lo = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   ptag_btb u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .lk_pc      (lk_pc),
      .lk_hit     (lk_hit),
      .lk_next_pc (lk_next_pc),
      .up_en      (up_en),
      .up_pc      (up_pc),
      .up_tgt_lo  (up_tgt_lo)
   );

   // Behavioural reference model.
   bit          m_v   [NSETS][NWAYS];
   int unsigned m_tag [NSETS][NWAYS];
   int unsigned m_tgt [NSETS][NWAYS];
   int          m_old [NSETS];   // way written longest ago

   function automatic int set_of(input logic [31:0] pc);
      return int'((pc >> 4) & 32'h3);
   endfunction

   function automatic int unsigned tag_of(input logic [31:0] pc);
      return (pc >> 6) & 32'hFFFF;
   endfunction

   function automatic void model_expect(input logic [31:0] pc,
                                        output bit hit,
                                        output logic [31:0] nxt);
      int s = set_of(pc);
      hit = 1'b0;
      nxt = pc + 32'd16;
      for (int w = 0; w < NWAYS; w++) begin
         if (m_v[s][w] && m_tag[s][w] == tag_of(pc)) begin
            hit = 1'b1;
            nxt = (pc & 32'hFF00_0000) | m_tgt[s][w];
         end
      end
   endfunction

   function automatic void model_clear();
      for (int s = 0; s < NSETS; s++) begin
         m_old[s] = 0;
         for (int w = 0; w < NWAYS; w++) m_v[s][w] = 1'b0;
      end
   endfunction

   function automatic void model_write(input logic [31:0] pc,
                                       input logic [23:0] tgt);
      int s = set_of(pc);
      int way = -1;
      for (int w = 0; w < NWAYS; w++) begin
         if (m_v[s][w] && m_tag[s][w] == tag_of(pc)) way = w;
      end
      if (way < 0) way = m_old[s];
      m_v[s][way]   = 1'b1;
      m_tag[s][way] = tag_of(pc);
      m_tgt[s][way] = {8'h00, tgt};
      m_old[s]      = 1 - way;
   endfunction

   task automatic report(input string req, input bit ok,
                         input bit ahit, input logic [31:0] anxt,
                         input bit ehit, input logic [31:0] enxt);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: hit=%0b next=%h expected hit=%0b next=%h",
                  req, ahit, anxt, ehit, enxt);
      end
   endtask

   // One cycle: drive, compare against model (and optional literal), clock.
   task automatic cyc(input bit f, input logic [31:0] lpc,
                      input bit ue, input logic [31:0] upc,
                      input logic [23:0] utgt, input string req,
                      input bit lit = 1'b0, input bit lhit = 1'b0,
                      input logic [31:0] lnxt = '0);
      bit          ehit;
      logic [31:0] enxt;
      @(negedge clk);
      flush = f; lk_pc = lpc; up_en = ue; up_pc = upc; up_tgt_lo = utgt;
      #2;
      model_expect(lpc, ehit, enxt);
      report(req, (lk_hit == ehit) && (lk_next_pc == enxt),
             lk_hit, lk_next_pc, ehit, enxt);
      if (lit) begin
         report(req, (lk_hit == lhit) && (lk_next_pc == lnxt),
                lk_hit, lk_next_pc, lhit, lnxt);
      end
      @(posedge clk);
      #1;
      if (f) model_clear();
      else if (ue) model_write(upc, utgt);
   endtask

   task automatic look(input logic [31:0] pc, input bit h,
                       input logic [31:0] n, input string req);
      cyc(1'b0, pc, 1'b0, '0, '0, req, 1'b1, h, n);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      model_clear();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 / R2: empty after reset, sequential next address
      look(32'h0000_1000, 1'b0, 32'h0000_1010, "R1");
      look(32'hFFFF_FFF8, 1'b0, 32'h0000_0008, "R2");

      // R9: install visible only from the next cycle
      cyc(1'b0, 32'h0000_1040, 1'b1, 32'h0000_1040, 24'h12_3456, "R9",
          1'b1, 1'b0, 32'h0000_1050);
      look(32'h0000_1040, 1'b1, 32'h0012_3456, "R3");
      // R4 / R5: upper bits spliced, bits outside the tag ignored
      look(32'hAB00_1044, 1'b1, 32'hAB12_3456, "R4");
      look(32'h0040_104F, 1'b1, 32'h0012_3456, "R5");
      look(32'h0000_1080, 1'b0, 32'h0000_1090, "R3");

      // R7: second way in the same set
      cyc(1'b0, 32'h0, 1'b1, 32'h0000_2040, 24'h0A_0000, "R7");
      look(32'h0000_2040, 1'b1, 32'h000A_0000, "R7");
      look(32'h0000_1040, 1'b1, 32'h0012_3456, "R7");

      // R6: refresh in place, other way kept
      cyc(1'b0, 32'h0, 1'b1, 32'h0000_1040, 24'h77_7777, "R6");
      look(32'h0000_1040, 1'b1, 32'h0077_7777, "R6");
      look(32'h0000_2040, 1'b1, 32'h000A_0000, "R6");

      // R7: third branch evicts the least recently written one
      cyc(1'b0, 32'h0, 1'b1, 32'h0000_3040, 24'h33_3333, "R7");
      look(32'h0000_2040, 1'b0, 32'h0000_2050, "R7");
      look(32'h0000_1040, 1'b1, 32'h0077_7777, "R7");
      look(32'h0000_3040, 1'b1, 32'h0033_3333, "R7");

      // R10: another set is independent
      cyc(1'b0, 32'h0, 1'b1, 32'h0000_1050, 24'h55_5555, "R10");
      look(32'h0000_1050, 1'b1, 32'h0055_5555, "R10");
      look(32'h0000_1040, 1'b1, 32'h0077_7777, "R10");

      // R8: flush clears all and drops a same-cycle update
      cyc(1'b1, 32'h0, 1'b1, 32'h0000_4040, 24'h44_4444, "R8");
      look(32'h0000_1040, 1'b0, 32'h0000_1050, "R8");
      look(32'h0000_4040, 1'b0, 32'h0000_4050, "R8");
      look(32'h0000_1050, 1'b0, 32'h0000_1060, "R8");

      // Random traffic against the model (R2 R3 R4 R5 R6 R7)
      for (int i = 0; i < 600; i++) begin
         logic [31:0] lpc = $urandom & 32'hFFC0_03FF;
         logic [31:0] upc = $urandom & 32'hFFC0_03FF;
         logic [23:0] tg  = 24'($urandom);
         bit          ue  = ($urandom % 3) != 0;
         bit          fl  = ($urandom % 60) == 0;
         cyc(fl, lpc, ue, upc, tg, "R3");
      end

      finish_run();
   end
endmodule